// File: doc/BRIEF.md
# UTOPIA Transmit Cell Intake

This block sits on the PHY side of a UTOPIA Level 2 transmit bus. An ATM-layer device pushes cells into it over a data bus that runs either 8 or 16 bits wide. A strobe marks the first word of every cell, and each word carries an odd parity bit. Accepted cells land in a four-cell octet FIFO. A downstream cell processor drains that FIFO one octet per cycle. It receives a start-of-cell marker with each first octet and watches a flag that reports whether a complete cell is waiting.

The block drives a cell-available handshake toward the ATM layer. This output is high only while a whole free cell slot remains. In multi-PHY operation the block answers polls and accepts transfers only at its own 5-bit address. Cells that are errored, through bad parity or through a start strobe that cuts the previous cell short, are either discarded or kept, depending on a drop option. A sticky error flag records that such a cell was seen.

Configuration inputs are expected to be static while cells are in flight. Everything runs on one clock.

Top module: `utx_cell_intake`

## Requirements
- R1: With `cfg_wide`=0 only `tx_data[7:0]` carries a cell octet. With `cfg_wide`=1 each word carries two octets, and `tx_data[15:8]` is the earlier one in the cell.
- R2: A cell holds 52 octets when `cfg_ext`=0. When `cfg_ext`=1 it holds 53 octets in 8-bit mode and 54 octets (27 words) in 16-bit mode. Exactly that many octets are delivered per cell.
- R3: An accepted word with `tx_soc`=1 opens a cell. Accepted words that arrive while no cell is open and carry `tx_soc`=0 are discarded.
- R4: `tx_prty` is odd parity over the active data bits (low byte in 8-bit mode, all 16 bits in 16-bit mode). A mismatch on any accepted word of a cell marks that cell errored.
- R5: A `tx_soc` that arrives before the open cell is complete marks the open cell as errored (runt) and opens the new cell.
- R6: In multi-PHY mode (`cfg_multi`=1), `tx_clav_oe` is 1 in the cycle after a cycle with `tx_enb`=1 and `tx_addr`=`cfg_addr`, and 0 otherwise. In single-PHY mode `tx_clav_oe` is 1 from the first clock after reset.
- R7: In multi-PHY mode words are accepted only after the last cycle with `tx_enb`=1 presented `cfg_addr`. In single-PHY mode `tx_addr` has no effect.
- R8: The FIFO holds 4 cells. `tx_clav` is 1 one cycle after there is room for one more whole cell, counting a cell still being received. A cell whose start arrives with the FIFO full is discarded.
- R9: With `cfg_drop`=1 an errored cell is discarded entirely. With `cfg_drop`=0 it is kept. Either way `cell_err_flag` rises and stays at 1 until reset.
- R10: Words presented while `tx_enb`=1 are ignored, including any `tx_soc` on them, and a cell may pause across such cycles.
- R11: While `rd_enb`=0 and `cell_present`=1, one octet is popped per clock. `rd_data` and `rd_soc` show it after that edge, and `rd_soc`=1 only on the first octet of a cell. `cell_present` is 1 while at least one complete cell is stored.
- R12: During reset `cell_present`, `tx_clav`, `tx_clav_oe`, `rd_soc` and `cell_err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and FIFO |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1: 16-bit data bus, 0: 8-bit |
| cfg_ext | input | 1 | 1: 53/54-octet cells, 0: 52-octet cells |
| cfg_multi | input | 1 | 1: multi-PHY addressed operation |
| cfg_drop | input | 1 | 1: discard errored cells |
| cfg_addr | input | 5 | This PHY's bus address |
| tx_data | input | 16 | Cell data from the ATM layer |
| tx_addr | input | 5 | PHY address for polling and selection |
| tx_enb | input | 1 | Active-low transfer enable |
| tx_soc | input | 1 | Start-of-cell strobe on the first word |
| tx_prty | input | 1 | Odd parity for the active data bits |
| tx_clav | output | 1 | Cell-available (room for one whole cell) |
| tx_clav_oe | output | 1 | Drive enable of the cell-available output |
| rd_enb | input | 1 | Active-low octet read enable |
| rd_data | output | 8 | Octet read from the FIFO |
| rd_soc | output | 1 | First octet of a cell on `rd_data` |
| cell_present | output | 1 | At least one complete cell stored |
| cell_err_flag | output | 1 | Sticky: an errored cell was received |

## Verification
The intake path is driven with clean cells in all four width and length combinations. Comparing every delivered octet separates correct byte order and cell length from off-by-one counting and swapped lanes. Parity faults are placed on the first, a middle and the last word under both drop settings. Runt cells are cut short by an early start strobe in both modes, which shows whether the drop rewinds only the errored cell and whether a kept runt and the following cell land in separate slots. Directed runs add: polls at the block's own and a foreign address; junk words with the enable high or with no preceding start strobe; a paused cell; and a fifth cell offered to a full FIFO. These show that the address, the enable and the FIFO limit gate intake as required.

// File: rtl/utx_pkg.sv
package utx_pkg;

   localparam int unsigned LANES = 2;

   // words per cell on the input bus
   function automatic logic [5:0] cell_words(input logic wide, input logic ext);
      if (wide) return ext ? 6'd27 : 6'd26;
      return ext ? 6'd53 : 6'd52;
   endfunction

   // octets per cell in the FIFO
   function automatic logic [5:0] cell_octets(input logic wide, input logic ext);
      if (wide) return ext ? 6'd54 : 6'd52;
      return ext ? 6'd53 : 6'd52;
   endfunction

endpackage

// File: rtl/utx_poll.sv
module utx_poll #(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_multi,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [ADDR_W-1:0] tx_addr,
   input  logic              tx_enb,
   input  logic              room,
   output logic              selected,
   output logic              clav,
   output logic              clav_oe
);

   logic hit;
   logic sel_q, clav_q, oe_q;

   assign hit = (tx_addr == cfg_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         clav_q <= 1'b0;
         oe_q   <= 1'b0;
      end else begin
         clav_q <= room;
         oe_q   <= !cfg_multi || (tx_enb && hit);
         if (tx_enb) sel_q <= hit;
      end
   end

   assign selected = !cfg_multi || sel_q;
   assign clav     = clav_q;
   assign clav_oe  = oe_q;

   // R6: in multi-PHY mode the drive enable follows only a poll at our address
   a_r6_oe_after_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_multi && $past(cfg_multi) && clav_oe) |->
         ($past(tx_enb) && ($past(tx_addr) == $past(cfg_addr))));

endmodule

// File: rtl/utx_writer.sv
module utx_writer
   import utx_pkg::*;
#(
   parameter int SLOTS = 4,
   parameter int IDX_W = 6,
   parameter int CNT_W = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_wide,
   input  logic                            cfg_ext,
   input  logic                            cfg_drop,
   input  logic                            selected,
   input  logic                            tx_enb,
   input  logic                            tx_soc,
   input  logic [15:0]                     tx_data,
   input  logic                            tx_prty,
   input  logic [CNT_W-1:0]                cnt,
   output logic                            in_cell,
   output logic                            commit,
   output logic                            wr_adv,
   output logic [LANES-1:0]                wr_en,
   output logic [LANES-1:0][IDX_W-1:0]     wr_idx,
   output logic [LANES-1:0][7:0]           wr_oct,
   output logic                            err_seen
);

   localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(SLOTS);

   logic             in_q, bad_q, err_q;
   logic [IDX_W-1:0] wcnt_q;
   logic             accept, perr, runt, keep_runt, start, cont, last;
   logic             bad_now, end_ok, write;
   logic [IDX_W-1:0] nwords, widx;
   logic [CNT_W:0]   cnt_after;

   always_comb begin
      nwords    = IDX_W'(cell_words(cfg_wide, cfg_ext));
      accept    = !tx_enb && selected;
      perr      = cfg_wide ? ~(^{tx_data, tx_prty}) : ~(^{tx_data[7:0], tx_prty});
      runt      = accept && tx_soc && in_q;
      keep_runt = runt && !cfg_drop;
      cnt_after = {1'b0, cnt} + {{CNT_W{1'b0}}, keep_runt};
      start     = accept && tx_soc && (cnt_after < LIMIT);
      cont      = accept && !tx_soc && in_q;
      last      = cont && (wcnt_q == nwords - 1'b1);
      bad_now   = bad_q | perr;
      end_ok    = last && !(bad_now && cfg_drop);
      write     = start | cont;
      widx      = start ? '0 : wcnt_q;
   end

   assign commit   = keep_runt | end_ok;
   assign wr_adv   = keep_runt;
   assign in_cell  = in_q;
   assign err_seen = err_q;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         if (l == 0) begin : g_first
            assign wr_en[l]  = write;
            assign wr_idx[l] = cfg_wide ? {widx[IDX_W-2:0], 1'b0} : widx;
            assign wr_oct[l] = cfg_wide ? tx_data[15:8] : tx_data[7:0];
         end else begin : g_second
            assign wr_en[l]  = write && cfg_wide;
            assign wr_idx[l] = {widx[IDX_W-2:0], 1'b1};
            assign wr_oct[l] = tx_data[7:0];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_q   <= 1'b0;
         bad_q  <= 1'b0;
         err_q  <= 1'b0;
         wcnt_q <= '0;
      end else begin
         if ((write && perr) || runt) err_q <= 1'b1;
         if (start) begin
            in_q   <= 1'b1;
            wcnt_q <= IDX_W'(1);
            bad_q  <= perr;
         end else if (last) begin
            in_q   <= 1'b0;
            wcnt_q <= '0;
            bad_q  <= 1'b0;
         end else if (cont) begin
            wcnt_q <= wcnt_q + 1'b1;
            bad_q  <= bad_now;
         end else if (runt) begin
            in_q   <= 1'b0;
            wcnt_q <= '0;
            bad_q  <= 1'b0;
         end
      end
   end

   // R2: an open cell never counts past its configured length
   a_r2_word_range: assert property (@(posedge clk) disable iff (!rst_n)
      in_q |-> (wcnt_q < nwords) && (wcnt_q != '0));

   // R3: a cell is handed to the FIFO only while one is open
   a_r3_commit_open: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> in_q);

   // R9: the error flag is sticky until reset
   a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);

endmodule

// File: rtl/utx_store.sv
module utx_store
   import utx_pkg::*;
#(
   parameter int  SLOTS       = 4,
   parameter int  SLOT_OCTETS = 64,
   localparam int SLOT_W      = $clog2(SLOTS),
   localparam int IDX_W       = $clog2(SLOT_OCTETS),
   localparam int CNT_W       = $clog2(SLOTS + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_wide,
   input  logic                        cfg_ext,
   input  logic [LANES-1:0]            wr_en,
   input  logic [LANES-1:0][IDX_W-1:0] wr_idx,
   input  logic [LANES-1:0][7:0]       wr_oct,
   input  logic                        wr_adv,
   input  logic                        commit,
   input  logic                        rd_enb,
   output logic [CNT_W-1:0]            cnt,
   output logic [7:0]                  rd_data,
   output logic                        rd_soc,
   output logic                        cell_present
);

   localparam int DEPTH = SLOTS * SLOT_OCTETS;

   logic [7:0]        mem [DEPTH];
   logic [SLOT_W-1:0] wr_slot_q, rd_slot_q, wslot;
   logic [IDX_W-1:0]  rd_idx_q, octs;
   logic [CNT_W-1:0]  cnt_q;
   logic              pop, last_rd;
   logic [SLOT_W+IDX_W-1:0] waddr [LANES];

   assign wslot   = wr_slot_q + SLOT_W'(wr_adv);
   assign octs    = IDX_W'(cell_octets(cfg_wide, cfg_ext));
   assign pop     = !rd_enb && (cnt_q != '0);
   assign last_rd = (rd_idx_q == octs - 1'b1);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_addr
         assign waddr[l] = {wslot, wr_idx[l]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
         if (wr_en[l]) mem[waddr[l]] <= wr_oct[l];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_slot_q <= '0;
         rd_slot_q <= '0;
         rd_idx_q  <= '0;
         cnt_q     <= '0;
         rd_data   <= '0;
         rd_soc    <= 1'b0;
      end else begin
         if (commit) wr_slot_q <= wr_slot_q + 1'b1;
         rd_soc <= 1'b0;
         if (pop) begin
            rd_data <= mem[{rd_slot_q, rd_idx_q}];
            rd_soc  <= (rd_idx_q == '0);
            if (last_rd) begin
               rd_idx_q  <= '0;
               rd_slot_q <= rd_slot_q + 1'b1;
            end else begin
               rd_idx_q <= rd_idx_q + 1'b1;
            end
         end
         cnt_q <= cnt_q + CNT_W'(commit) - CNT_W'(pop && last_rd);
      end
   end

   assign cnt          = cnt_q;
   assign cell_present = (cnt_q != '0);

   // R8: the writer never completes a cell into a full FIFO
   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (cnt_q < CNT_W'(SLOTS)));

   // R11: the start marker marks a single octet, never two in a row
   a_r11_soc_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_soc |=> !rd_soc);

endmodule

// File: rtl/utx_cell_intake.sv
module utx_cell_intake
   import utx_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int SLOTS       = 4,
   parameter int SLOT_OCTETS = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wide,
   input  logic              cfg_ext,
   input  logic              cfg_multi,
   input  logic              cfg_drop,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [15:0]       tx_data,
   input  logic [ADDR_W-1:0] tx_addr,
   input  logic              tx_enb,
   input  logic              tx_soc,
   input  logic              tx_prty,
   output logic              tx_clav,
   output logic              tx_clav_oe,
   input  logic              rd_enb,
   output logic [7:0]        rd_data,
   output logic              rd_soc,
   output logic              cell_present,
   output logic              cell_err_flag
);

   localparam int IDX_W = $clog2(SLOT_OCTETS);
   localparam int CNT_W = $clog2(SLOTS + 1);

   initial begin
      assert (SLOTS >= 2 && (SLOTS & (SLOTS - 1)) == 0)
         else $error("SLOTS must be a power of two of at least 2");
      assert (SLOT_OCTETS >= 54 && (SLOT_OCTETS & (SLOT_OCTETS - 1)) == 0)
         else $error("SLOT_OCTETS must be a power of two holding 54 octets");
      assert (ADDR_W >= 1) else $error("ADDR_W must be positive");
   end

   logic                        selected, room, in_cell, commit, wr_adv;
   logic [CNT_W-1:0]            cnt;
   logic [LANES-1:0]            wr_en;
   logic [LANES-1:0][IDX_W-1:0] wr_idx;
   logic [LANES-1:0][7:0]       wr_oct;

   assign room = (({1'b0, cnt} + {{CNT_W{1'b0}}, in_cell}) < (CNT_W+1)'(SLOTS));

   utx_poll #(.ADDR_W(ADDR_W)) u_poll (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_multi(cfg_multi),
      .cfg_addr (cfg_addr),
      .tx_addr  (tx_addr),
      .tx_enb   (tx_enb),
      .room     (room),
      .selected (selected),
      .clav     (tx_clav),
      .clav_oe  (tx_clav_oe)
   );

   utx_writer #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_writer (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_wide(cfg_wide),
      .cfg_ext (cfg_ext),
      .cfg_drop(cfg_drop),
      .selected(selected),
      .tx_enb  (tx_enb),
      .tx_soc  (tx_soc),
      .tx_data (tx_data),
      .tx_prty (tx_prty),
      .cnt     (cnt),
      .in_cell (in_cell),
      .commit  (commit),
      .wr_adv  (wr_adv),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_oct  (wr_oct),
      .err_seen(cell_err_flag)
   );

   utx_store #(.SLOTS(SLOTS), .SLOT_OCTETS(SLOT_OCTETS)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wide    (cfg_wide),
      .cfg_ext     (cfg_ext),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .wr_oct      (wr_oct),
      .wr_adv      (wr_adv),
      .commit      (commit),
      .rd_enb      (rd_enb),
      .cnt         (cnt),
      .rd_data     (rd_data),
      .rd_soc      (rd_soc),
      .cell_present(cell_present)
   );

endmodule

// File: tb/utx_cell_intake_test.sv
module utx_cell_intake_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wide = 1'b0, cfg_ext = 1'b0, cfg_multi = 1'b0, cfg_drop = 1'b0;
   logic [4:0]  cfg_addr = 5'd5;
   logic [15:0] tx_data = '0;
   logic [4:0]  tx_addr = '0;
   logic        tx_enb = 1'b1, tx_soc = 1'b0, tx_prty = 1'b0;
   logic        tx_clav, tx_clav_oe;
   logic        rd_enb = 1'b1;
   logic [7:0]  rd_data;
   logic        rd_soc, cell_present, cell_err_flag;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   utx_cell_intake uut (
      .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_ext(cfg_ext),
      .cfg_multi(cfg_multi), .cfg_drop(cfg_drop), .cfg_addr(cfg_addr),
      .tx_data(tx_data), .tx_addr(tx_addr), .tx_enb(tx_enb), .tx_soc(tx_soc),
      .tx_prty(tx_prty), .tx_clav(tx_clav), .tx_clav_oe(tx_clav_oe),
      .rd_enb(rd_enb), .rd_data(rd_data), .rd_soc(rd_soc),
      .cell_present(cell_present), .cell_err_flag(cell_err_flag)
   );

   // {wide, ext, multi, drop, bad word (FF none), runt length (0 none)}
   localparam logic [19:0] VECS [11] = '{
      20'h1FF00, 20'h4FF00, 20'h8FF00, 20'hEFF00, 20'h10A00, 20'h00000,
      20'hDFF05, 20'h8FF03, 20'h43400, 20'hF1A00, 20'h3FF07
   };

   task automatic check(input string req, input int act, input int exp_v);
      n_chk++;
      if (act != exp_v) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      tx_enb = 1'b1; tx_soc = 1'b0; rd_enb = 1'b1;
      rst_n = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   function automatic int n_words();
      if (cfg_wide) return cfg_ext ? 27 : 26;
      return cfg_ext ? 53 : 52;
   endfunction

   function automatic int n_octs();
      if (cfg_wide) return cfg_ext ? 54 : 52;
      return cfg_ext ? 53 : 52;
   endfunction

   // drive one word per accepted cycle; optional pause with enable high
   task automatic send_cell(input logic [7:0] seed, input int words, input int bad, input bit gaps);
      for (int i = 0; i < words; i++) begin
         if (gaps && (i == 3 || i == 10)) begin
            tx_enb = 1'b1; tx_soc = 1'b1; tx_data = 16'hFFFF; tx_prty = 1'b0;
            tick();
         end
         tx_enb = 1'b0;
         tx_soc = (i == 0);
         if (cfg_wide) tx_data = {seed + 8'(2*i), seed + 8'(2*i + 1)};
         else          tx_data = {8'h01, seed + 8'(i)};
         tx_prty = cfg_wide ? ~^tx_data : ~^tx_data[7:0];
         if (i == bad) tx_prty = ~tx_prty;
         tick();
      end
      tx_enb = 1'b1;
      tx_soc = 1'b0;
   endtask

   task automatic read_cell(input string req, input logic [7:0] seed, input int noct, input int ncheck);
      check({req, " R11 present before read"}, cell_present, 1);
      rd_enb = 1'b0;
      for (int k = 0; k < noct; k++) begin
         tick();
         if (k < ncheck) check({req, " octet"}, rd_data, seed + 8'(k));
         check({req, " R11 soc"}, rd_soc, (k == 0));
      end
      rd_enb = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R12: reset values
      rst_n = 1'b0;
      tick(); tick();
      check("R12 present", cell_present, 0);
      check("R12 clav", tx_clav, 0);
      check("R12 oe", tx_clav_oe, 0);
      check("R12 soc", rd_soc, 0);
      check("R12 err", cell_err_flag, 0);
      rst_n = 1'b1;
      tick();
      check("R6 single oe", tx_clav_oe, 1);
      check("R8 clav empty", tx_clav, 1);

      // vector walk: R1 R2 R4 R5 R9
      for (int v = 0; v < 11; v++) begin
         logic [19:0] vec;
         int bad, runt, opw;
         vec = VECS[v];
         cfg_wide = vec[19]; cfg_ext = vec[18]; cfg_multi = vec[17]; cfg_drop = vec[16];
         bad  = (vec[15:8] == 8'hFF) ? -1 : int'(vec[15:8]);
         runt = int'(vec[7:0]);
         opw  = cfg_wide ? 2 : 1;
         tx_addr = 5'd0;
         do_reset();
         if (cfg_multi) begin
            tx_addr = cfg_addr;
            tick();
         end
         if (runt != 0) send_cell(8'h40, runt, -1, 0);
         send_cell(8'h80, n_words(), bad, 0);
         tick(); tick();
         check($sformatf("R9 vec%0d sticky", v), cell_err_flag, (bad >= 0 || runt != 0));
         if (runt != 0 && !cfg_drop)
            read_cell($sformatf("R5 vec%0d runt kept", v), 8'h40, n_octs(), runt * opw);
         if (bad < 0 || !cfg_drop)
            read_cell($sformatf("R1 R2 R4 vec%0d", v), 8'h80, n_octs(), n_octs());
         tick();
         check($sformatf("R2 R9 vec%0d empty after", v), cell_present, 0);
      end

      // R6 R7: multi-PHY polling and selection
      cfg_wide = 1'b0; cfg_ext = 1'b0; cfg_multi = 1'b1; cfg_drop = 1'b0;
      tx_addr = 5'd0;
      do_reset();
      check("R6 oe foreign idle", tx_clav_oe, 0);
      tx_addr = cfg_addr;
      tick();
      check("R6 oe own poll", tx_clav_oe, 1);
      check("R6 clav own poll", tx_clav, 1);
      tx_addr = 5'd9;
      tick();
      check("R6 oe foreign poll", tx_clav_oe, 0);
      send_cell(8'h20, n_words(), -1, 0);
      tick(); tick();
      check("R7 unselected ignored", cell_present, 0);
      check("R7 unselected no err", cell_err_flag, 0);
      tx_addr = cfg_addr;
      tick();
      tx_addr = 5'd9;
      send_cell(8'h30, n_words(), -1, 0);
      check("R6 oe off after enable", tx_clav_oe, 0);
      tick();
      read_cell("R7 selected", 8'h30, n_octs(), n_octs());

      // R3 R10: junk words, then a paused cell
      cfg_multi = 1'b0; cfg_ext = 1'b1;
      do_reset();
      for (int j = 0; j < 3; j++) begin
         tx_enb = 1'b1; tx_soc = 1'b1; tx_data = 16'h0055; tx_prty = 1'b1;
         tick();
      end
      for (int j = 0; j < 5; j++) begin
         tx_enb = 1'b0; tx_soc = 1'b0; tx_data = 16'h0077; tx_prty = 1'b0;
         tick();
      end
      tx_enb = 1'b1;
      tick(); tick();
      check("R10 R3 junk ignored", cell_present, 0);
      check("R3 junk no err", cell_err_flag, 0);
      send_cell(8'h55, n_words(), -1, 1);
      tick();
      read_cell("R10 paused cell", 8'h55, n_octs(), n_octs());
      tick();
      check("R10 single cell only", cell_present, 0);

      // R8: fill four slots, offer a fifth
      cfg_ext = 1'b0;
      do_reset();
      for (int c = 0; c < 4; c++) send_cell(8'h10 * 8'(c + 1), n_words(), -1, 0);
      tick(); tick();
      check("R8 clav full", tx_clav, 0);
      send_cell(8'h99, n_words(), -1, 0);
      tick();
      for (int c = 0; c < 4; c++)
         read_cell($sformatf("R8 cell%0d", c), 8'h10 * 8'(c + 1), n_octs(), n_octs());
      tick();
      check("R8 fifth dropped", cell_present, 0);
      check("R8 clav free again", tx_clav, 1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule